// File: doc/BRIEF.md
# Serial Sector Write Formatter

The formatter produces the complete serial bit stream for writing one disk sector, one bit per clock. On a start pulse it latches the sector address and the sector length. It then emits a run of preamble ones, a fixed sync word, the two address bytes, the data bytes pulled from a byte cache, a 16-bit CRC and a zero postamble. A write-enable line is held high across the whole field. A one-cycle done pulse follows the last bit. Line encoding such as MFM is applied further downstream and is not part of this block.

Two byte-wide shift registers take turns as the serialiser. While one shifts a byte out, the other is refilled from the cache, so the stream never pauses between bytes. The CRC (polynomial 0x1021, preset zero, most significant bit first) accumulates over every address and data bit. After the last data bit, the CRC register is switched straight onto the line and shifted out. A sector written this way therefore reads back with a zero remainder over the address, data and CRC bits.

The cache side is a valid/ready stream. The formatter raises `cache_ready` for exactly one cycle per data byte and takes `cache_data` at the clock edge that ends that cycle. The serial output cannot stall, so there is no back-pressure from the formatter's side other than the timing of `cache_ready`. The cache must present valid data whenever `cache_ready` is high. A byte offered while `cache_ready` is low is not consumed.

Top module: `sector_write_formatter`

## Requirements
- R1: After reset, wr_en, wr_data, done and cache_ready are all 0.
- R2: A start pulse is accepted only while the block is idle, and wr_en rises in the cycle after the accepting edge. A start pulse, or a change of sect_addr or sect_len, during a frame has no effect on that frame or on the idle state that follows it.
- R3: The frame opens with PRE_LEN (default 12) bits of 1.
- R4: The preamble is followed by the SYNC_W-bit sync word SYNC_WORD (default 16'h0001), sent most significant bit first.
- R5: The sync word is followed by sect_addr[15:8] and then sect_addr[7:0], each sent most significant bit first, using the values latched at start.
- R6: The address is followed by exactly sect_len data bytes (0 to MAX_LEN), sent in cache order and most significant bit first. A length of 0 sends the header and the CRC with no data.
- R7: cache_ready is high for exactly one cycle per data byte. Data byte m (counting from 0) is requested in the cycle at bit offset 36+8m from the first preamble bit, and the byte is taken at the edge that ends that cycle.
- R8: The data is followed by 16 CRC bits, most significant bit first. The CRC uses polynomial 0x1021 with a zero preset over all address and data bits, so the CRC of the address, data and CRC bits taken together is zero.
- R9: The CRC is followed by 32 zero bits, with wr_en still high.
- R10: wr_en stays high without a gap from the first preamble bit to the last postamble bit. wr_data is 0 whenever wr_en is low. done is high for exactly the one cycle after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sector write (taken when idle) |
| sect_addr | input | 16 | Two address bytes, high byte sent first |
| sect_len | input | 9 | Number of data bytes in the sector |
| cache_valid | input | 1 | Cache data word is valid |
| cache_data | input | 8 | Byte offered by the cache |
| cache_ready | output | 1 | Formatter takes cache_data at this cycle's edge |
| wr_data | output | 1 | Serial write data |
| wr_en | output | 1 | Write enable spanning the whole field |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The assertions take for granted that start is a clean pulse and that the cache holds cache_valid high, with correct data, in every cycle where cache_ready is high. Under that assumption, every request is served at once and the bit stream never depends on a missing byte. The stimulus drives the cache as an always-valid memory that steps to the next byte only after an edge on which cache_ready was seen. It raises start only with a settled address and length, except for the deliberate mid-frame pulse that checks R2. Sector lengths of 0, 1, a few bytes and the full MAX_LEN are covered.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_SYNC = 3'd2,
    PH_BODY = 3'd3,
    PH_CRC  = 3'd4,
    PH_POST = 3'd5,
    PH_DONE = 3'd6
  } phase_e;
endpackage

// File: rtl/swf_seq.sv
module swf_seq
  import swf_pkg::*;
#(
  parameter int PRE_LEN = 12,
  parameter int SYNC_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int CRC_W   = 16,
  parameter int POST_W  = 32,
  parameter int LEN_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] sect_len,
  output phase_e           phase,
  output logic             sel,
  output logic             accept,
  output logic             fetch
);
  localparam int M1   = (PRE_LEN > SYNC_W) ? PRE_LEN : SYNC_W;
  localparam int M2   = (M1 > POST_W) ? M1 : POST_W;
  localparam int M3   = (M2 > CRC_W) ? M2 : CRC_W;
  localparam int MAXC = (M3 > BYTE_W) ? M3 : BYTE_W;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int K_W   = LEN_W + 1;

  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_W - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [K_W-1:0]   kidx_q;
  logic [LEN_W-1:0] len_q;
  logic             sel_q;
  logic [K_W-1:0]   last_k;

  // byte index runs over both address bytes and the data bytes
  assign last_k = {1'b0, len_q} + K_W'(1);
  assign phase  = phase_q;
  assign sel    = sel_q;
  assign accept = (phase_q == PH_IDLE) && start;
  // refill the idle register during the first bit of the byte before it
  assign fetch  = (phase_q == PH_BODY) && (cnt_q == '0) &&
                  (kidx_q != '0) && (kidx_q <= {1'b0, len_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      kidx_q  <= '0;
      len_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_PRE;
            cnt_q   <= '0;
            len_q   <= sect_len;
          end
        end
        PH_PRE: begin
          if (cnt_q == PRE_LAST) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_SYNC: begin
          if (cnt_q == SYNC_LAST) begin
            phase_q <= PH_BODY;
            cnt_q   <= '0;
            kidx_q  <= '0;
            sel_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_BODY: begin
          if (cnt_q == BYTE_LAST) begin
            cnt_q <= '0;
            if (kidx_q == last_k) begin
              phase_q <= PH_CRC;
            end else begin
              kidx_q <= kidx_q + K_W'(1);
              sel_q  <= ~sel_q;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_CRC: begin
          if (cnt_q == CRC_LAST) begin
            phase_q <= PH_POST;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_POST: begin
          if (cnt_q == POST_LAST) begin
            phase_q <= PH_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swf_byte_sr.sv
module swf_byte_sr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end else if (shift) begin
      q <= {q[W-2:0], 1'b0};
    end
  end

  assign msb = q[W-1];
endmodule

// File: rtl/swf_crc16.sv
module swf_crc16 #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic acc,
  input  logic din,
  input  logic drain,
  output logic msb
);
  logic [W-1:0] q;
  logic         fb;

  assign fb = q[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= INIT;
    end else if (clr) begin
      q <= INIT;
    end else if (acc) begin
      q <= {q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (drain) begin
      // the register itself becomes the serialiser for the check word
      q <= {q[W-2:0], 1'b0};
    end
  end

  assign msb = q[W-1];
endmodule

// File: rtl/sector_write_formatter.sv
module sector_write_formatter
  import swf_pkg::*;
#(
  parameter int                PRE_LEN    = 12,
  parameter int                SYNC_W     = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD  = 16'h0001,
  parameter int                BYTE_W     = 8,
  parameter int                CRC_W      = 16,
  parameter logic [CRC_W-1:0]  CRC_POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT   = '0,
  parameter int                POST_WORDS = 2,
  parameter int                MAX_LEN    = 256,
  localparam int               LEN_W      = $clog2(MAX_LEN + 1),
  localparam int               ADDR_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] sect_addr,
  input  logic [LEN_W-1:0]  sect_len,
  input  logic              cache_valid,
  input  logic [BYTE_W-1:0] cache_data,
  output logic              cache_ready,
  output logic              wr_data,
  output logic              wr_en,
  output logic              done
);
  localparam int POST_W = POST_WORDS * CRC_W;

  phase_e            phase;
  logic              sel;
  logic              accept;
  logic              fetch;
  logic              take;
  logic [1:0]        sr_msb;
  logic              crc_msb;
  logic              body_bit;
  logic [SYNC_W-1:0] sync_q;

  swf_seq #(
    .PRE_LEN(PRE_LEN), .SYNC_W(SYNC_W), .BYTE_W(BYTE_W),
    .CRC_W(CRC_W), .POST_W(POST_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_len(sect_len),
    .phase(phase), .sel(sel), .accept(accept), .fetch(fetch)
  );

  assign cache_ready = fetch;
  assign take        = fetch && cache_valid;

  // register 0 starts with the high address byte, register 1 with the low
  for (genvar g = 0; g < 2; g++) begin : g_sr
    logic              ld;
    logic              sh;
    logic [BYTE_W-1:0] dsel;
    assign ld   = accept || (take && (sel != 1'(g)));
    assign sh   = (phase == PH_BODY) && (sel == 1'(g));
    assign dsel = accept ? sect_addr[(1-g)*BYTE_W +: BYTE_W] : cache_data;
    swf_byte_sr #(.W(BYTE_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .load(ld), .din(dsel),
      .shift(sh), .msb(sr_msb[g])
    );
  end

  assign body_bit = sr_msb[sel];

  swf_crc16 #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .acc(phase == PH_BODY), .din(body_bit),
    .drain(phase == PH_CRC), .msb(crc_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else if (accept) begin
      sync_q <= SYNC_WORD;
    end else if (phase == PH_SYNC) begin
      sync_q <= {sync_q[SYNC_W-2:0], 1'b0};
    end
  end

  always_comb begin
    case (phase)
      PH_PRE:  wr_data = 1'b1;
      PH_SYNC: wr_data = sync_q[SYNC_W-1];
      PH_BODY: wr_data = body_bit;
      PH_CRC:  wr_data = crc_msb;
      default: wr_data = 1'b0;
    endcase
  end

  assign wr_en = (phase == PH_PRE) || (phase == PH_SYNC) || (phase == PH_BODY) ||
                 (phase == PH_CRC) || (phase == PH_POST);
  assign done  = (phase == PH_DONE);
endmodule

// File: rtl/swf_checker.sv
module swf_checker #(
  parameter int PRE_LEN = 12
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic wr_en,
  input logic wr_data,
  input logic done,
  input logic cache_ready
);
  localparam int PC_W = $clog2(PRE_LEN + 1);
  logic [PC_W-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !wr_en) begin
      pre_cnt <= '0;
    end else if (pre_cnt < PC_W'(PRE_LEN)) begin
      pre_cnt <= pre_cnt + PC_W'(1);
    end
  end

  p_pre_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pre_cnt < PC_W'(PRE_LEN)) |-> wr_data);
  p_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(start));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_data);
  p_fall_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> done);
  p_done_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && $past(wr_en)));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cache_ready |-> wr_en);
  p_ready_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cache_ready |=> !cache_ready);
endmodule

bind sector_write_formatter swf_checker #(.PRE_LEN(PRE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
  .wr_data(wr_data), .done(done), .cache_ready(cache_ready)
);

// File: tb/sim_sector_write_formatter.sv
module sim_sector_write_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int PRE    = 12;
  localparam logic [15:0] SYNCW = 16'h0001;
  localparam int POSTB  = 32;
  localparam int FIRST_REQ = PRE + 16 + 8;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic [15:0] sect_addr = '0;
  logic [8:0] sect_len = '0;
  logic       cache_valid = 1;
  logic [7:0] cache_data = '0;
  logic       cache_ready, wr_data, wr_en, done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_write_formatter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_addr(sect_addr),
    .sect_len(sect_len), .cache_valid(cache_valid), .cache_data(cache_data),
    .cache_ready(cache_ready), .wr_data(wr_data), .wr_en(wr_en), .done(done)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crc_bits(bit b[$], int from, int n);
    logic [15:0] c = 16'h0000;
    for (int i = from; i < from + n; i++) begin
      logic f = c[15] ^ b[i];
      c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  task automatic run_frame(input logic [15:0] addr, input int len, input int seed,
                           input bit poke);
    bit   bits[$];
    bit   got[$];
    byte  mem[$];
    int   idx = 0;
    int   nreq = 0;
    bit   prev_rdy = 0;
    int   total;
    int   dend;
    logic [15:0] crc;
    string tag;
    for (int i = 0; i < len; i++) mem.push_back(byte'((seed * 37 + i * 13 + 5) & 255));
    for (int i = 0; i < PRE; i++) bits.push_back(1'b1);
    for (int i = 15; i >= 0; i--) bits.push_back(SYNCW[i]);
    for (int i = 15; i >= 0; i--) bits.push_back(addr[i]);
    for (int m = 0; m < len; m++)
      for (int i = 7; i >= 0; i--) bits.push_back(mem[m][i]);
    crc = crc_bits(bits, PRE + 16, 16 + 8 * len);
    for (int i = 15; i >= 0; i--) bits.push_back(crc[i]);
    for (int i = 0; i < POSTB; i++) bits.push_back(1'b0);
    total = bits.size();
    dend  = PRE + 32 + 8 * len;
    cache_data = (len > 0) ? mem[0] : 8'h00;
    @(negedge clk);
    start = 1; sect_addr = addr; sect_len = 9'(len);
    @(negedge clk);
    start = 0;
    for (int i = 0; i <= total + 1; i++) begin
      bit exp_rdy;
      if (prev_rdy) begin
        idx++;
        cache_data = (idx < len) ? mem[idx] : 8'h00;
      end
      if (i < PRE) tag = "R3";
      else if (i < PRE + 16) tag = "R4";
      else if (i < PRE + 32) tag = "R5";
      else if (i < dend) tag = "R6";
      else if (i < dend + 16) tag = "R8";
      else if (i < total) tag = "R9";
      else tag = "R10";
      exp_rdy = (i >= FIRST_REQ) && ((i - FIRST_REQ) % 8 == 0) &&
                ((i - FIRST_REQ) / 8 < len);
      chk(tag, int'(wr_data), (i < total) ? int'(bits[i]) : 0);
      chk("R10 wr_en", int'(wr_en), (i < total) ? 1 : 0);
      chk("R10 done", int'(done), (i == total) ? 1 : 0);
      chk("R7 cache_ready", int'(cache_ready), int'(exp_rdy));
      if (i < total) got.push_back(wr_data);
      if (cache_ready) nreq++;
      prev_rdy = cache_ready;
      if (poke && i == 20) begin
        start = 1; sect_addr = ~addr; sect_len = 9'(len + 3);
      end
      if (poke && i == 21) begin
        start = 0;
      end
      @(negedge clk);
    end
    chk("R7 request count", nreq, len);
    chk("R8 readback remainder", int'(crc_bits(got, PRE + 16, 32 + 8 * len)), 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        chk("R2 stray start ignored", int'(wr_en), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 wr_data", int'(wr_data), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cache_ready", int'(cache_ready), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(wr_en), 0);
    run_frame(16'h1234, 1, 1, 0);
    run_frame(16'hABCD, 0, 2, 0);
    run_frame(16'h00FF, 5, 3, 1);
    run_frame(16'hFFFF, 16, 4, 0);
    run_frame(16'h5A5A, 256, 5, 0);
    run_frame(16'h8001, 2, 6, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule